// File: doc/BRIEF.md
# Return Address Integrity Monitor

This block sits beside a host processor and watches its stream of retired instructions. Each cycle it sees whether an instruction retired, that instruction's address and byte size, whether it was a call or a return, and where control actually went next. When a call retires, the monitor pushes the address of the instruction that follows it (call address plus size) onto a private hardware shadow stack. When a return retires, it pops the newest entry and compares that entry with the real return target.

A wrong target, a return with nothing on the stack, or a call and a return flagged in the same cycle counts as a violation. The monitor then raises a halt request to the host and fires a one-cycle nonmaskable interrupt. It captures the address of the offending instruction, the address it expected, and a fault code. The halt holds until recovery logic pulses the clear input. A call that finds the stack full is not stored. Instead it sets a sticky overflow status, so software can see that deeper returns can no longer be vouched for. The monitor asks the host to hold for one cycle while each return is being checked.

Top module: `ret_guard`

## Requirements
- R1: A retired call pushes its address plus its size. A later retired return whose next address equals that value raises no fault: halt, NMI and the fault code stay 0.
- R2: A retired return whose next address differs from the newest saved value sets halt on the following clock edge. It pulses NMI high for exactly one cycle and sets the fault code to 1 (mismatch). The entry is popped either way.
- R3: Saved addresses are checked in last-in first-out order. Each return is compared with the entry of the most recent call that is still open.
- R4: A retired return on an empty stack is a violation with fault code 2, and the captured expected address is 0.
- R5: The stack holds DEPTH entries (default 32). A call on a full stack stores nothing and sets a sticky overflow output. The DEPTH entries already stored stay intact and are returned in order.
- R6: A call and a return retiring in the same cycle is a protocol violation with fault code 3 and expected address 0. The stack is not changed.
- R7: On a violation, fault_pc holds the address of the offending instruction and fault_exp holds the expected target. While halt is high, retired instructions are ignored and these registers keep the first fault.
- R8: Halt stays high until fault_clear is pulsed. The edge that samples fault_clear drops halt and clears the fault code and the overflow status. Retirement in that same cycle is ignored.
- R9: stall is high, combinationally, in exactly the cycles in which a return retires while halt is low.
- R10: After reset, halt, NMI, stall, overflow, the fault code and both fault address registers are 0.
- R11: Call and return flags given with the retire valid low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_valid | input | 1 | An instruction retired this cycle |
| rt_pc | input | ADDR_W | Address of the retired instruction |
| rt_size | input | SIZE_W | Byte size of the retired instruction |
| rt_is_call | input | 1 | Retired instruction is a call |
| rt_is_ret | input | 1 | Retired instruction is a return |
| rt_next_pc | input | ADDR_W | Address actually executed next |
| fault_clear | input | 1 | Pulse to release halt and clear status |
| stall_o | output | 1 | Hold the host while a return is checked |
| halt_o | output | 1 | Halt request to the host |
| nmi_o | output | 1 | One-cycle nonmaskable interrupt pulse |
| ovf_o | output | 1 | Sticky shadow stack overflow |
| fault_kind_o | output | 2 | 0 none, 1 mismatch, 2 empty, 3 protocol |
| fault_pc_o | output | ADDR_W | Address of the offending instruction |
| fault_exp_o | output | ADDR_W | Expected return target of the fault |

## Verification
stall is a function of the present inputs and the halt register, so it is due in the very cycle a return is driven. The bench samples it one time unit after driving, well before the next rising edge. Halt, NMI, the fault code, the fault addresses and overflow are registered and change on the rising edge that samples the retirement. The driver therefore queues its expected values at that edge, and the monitor compares them at the following falling edge. An NMI seen at that sample must be gone at the next one, which checks that it lasts a single cycle.

// File: rtl/ret_guard_pkg.sv
package ret_guard_pkg;
    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_MISMATCH = 2'd1,
        FLT_EMPTY    = 2'd2,
        FLT_PROTO    = 2'd3
    } fault_e;
endpackage

// File: rtl/ret_guard_stack.sv
module ret_guard_stack #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_data_i,
    output logic [ADDR_W-1:0] top_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int PW = $clog2(DEPTH);

    logic [PW:0]       cnt_d, cnt_q;
    logic [PW-1:0]     wr_idx;
    logic [PW-1:0]     rd_idx;
    logic [ADDR_W-1:0] mem_q [DEPTH];

    assign wr_idx  = cnt_q[PW-1:0];
    assign rd_idx  = PW'(cnt_q - 1'b1);
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == (PW+1)'(DEPTH));
    assign top_o   = mem_q[rd_idx];

    always_comb begin
        cnt_d = cnt_q;
        if (push_i && !full_o) begin
            cnt_d = cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_i && !full_o && (wr_idx == PW'(gi))) begin
                mem_q[gi] <= push_data_i;
            end
        end
    end
endmodule

// File: rtl/ret_guard_ctrl.sv
module ret_guard_ctrl
    import ret_guard_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rt_valid,
    input  logic [ADDR_W-1:0] rt_pc,
    input  logic [SIZE_W-1:0] rt_size,
    input  logic              rt_is_call,
    input  logic              rt_is_ret,
    input  logic [ADDR_W-1:0] rt_next_pc,
    input  logic              fault_clear,
    input  logic [ADDR_W-1:0] top_i,
    input  logic              empty_i,
    input  logic              full_i,
    output logic              push_o,
    output logic              pop_o,
    output logic [ADDR_W-1:0] push_data_o,
    output logic              stall_o,
    output logic              halt_o,
    output logic              nmi_o,
    output logic              ovf_o,
    output logic [1:0]        fault_kind_o,
    output logic [ADDR_W-1:0] fault_pc_o,
    output logic [ADDR_W-1:0] fault_exp_o
);
    typedef struct packed {
        logic              halt;
        logic              nmi;
        logic              ovf;
        fault_e            kind;
        logic [ADDR_W-1:0] fpc;
        logic [ADDR_W-1:0] fexp;
    } state_t;

    state_t st_d, st_q;
    logic   live;
    logic   is_call_only;
    logic   is_ret_only;
    logic   flt;
    fault_e flt_kind;
    logic [ADDR_W-1:0] flt_exp;

    assign live         = rt_valid && !st_q.halt && !fault_clear;
    assign is_call_only = rt_is_call && !rt_is_ret;
    assign is_ret_only  = rt_is_ret && !rt_is_call;
    assign push_data_o  = rt_pc + ADDR_W'(rt_size);
    assign push_o       = live && is_call_only && !full_i;
    assign pop_o        = live && is_ret_only && !empty_i;
    assign stall_o      = rt_valid && rt_is_ret && !st_q.halt;

    always_comb begin
        flt      = 1'b0;
        flt_kind = FLT_NONE;
        flt_exp  = '0;
        if (live) begin
            if (rt_is_call && rt_is_ret) begin
                flt      = 1'b1;
                flt_kind = FLT_PROTO;
            end else if (is_ret_only) begin
                if (empty_i) begin
                    flt      = 1'b1;
                    flt_kind = FLT_EMPTY;
                end else if (top_i != rt_next_pc) begin
                    flt      = 1'b1;
                    flt_kind = FLT_MISMATCH;
                    flt_exp  = top_i;
                end
            end
        end

        st_d     = st_q;
        st_d.nmi = 1'b0;
        if (fault_clear) begin
            st_d.halt = 1'b0;
            st_d.ovf  = 1'b0;
            st_d.kind = FLT_NONE;
        end else if (live && is_call_only && full_i) begin
            st_d.ovf = 1'b1;
        end
        if (flt) begin
            st_d.halt = 1'b1;
            st_d.nmi  = 1'b1;
            st_d.kind = flt_kind;
            st_d.fpc  = rt_pc;
            st_d.fexp = flt_exp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{halt: 1'b0, nmi: 1'b0, ovf: 1'b0, kind: FLT_NONE,
                      fpc: '0, fexp: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_o       = st_q.halt;
    assign nmi_o        = st_q.nmi;
    assign ovf_o        = st_q.ovf;
    assign fault_kind_o = st_q.kind;
    assign fault_pc_o   = st_q.fpc;
    assign fault_exp_o  = st_q.fexp;
endmodule

// File: rtl/ret_guard.sv
module ret_guard #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rt_valid,
    input  logic [ADDR_W-1:0] rt_pc,
    input  logic [SIZE_W-1:0] rt_size,
    input  logic              rt_is_call,
    input  logic              rt_is_ret,
    input  logic [ADDR_W-1:0] rt_next_pc,
    input  logic              fault_clear,
    output logic              stall_o,
    output logic              halt_o,
    output logic              nmi_o,
    output logic              ovf_o,
    output logic [1:0]        fault_kind_o,
    output logic [ADDR_W-1:0] fault_pc_o,
    output logic [ADDR_W-1:0] fault_exp_o
);
    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] push_data;
    logic [ADDR_W-1:0] top;
    logic              empty;
    logic              full;

    ret_guard_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (top),
        .empty_o     (empty),
        .full_o      (full)
    );

    ret_guard_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rt_valid     (rt_valid),
        .rt_pc        (rt_pc),
        .rt_size      (rt_size),
        .rt_is_call   (rt_is_call),
        .rt_is_ret    (rt_is_ret),
        .rt_next_pc   (rt_next_pc),
        .fault_clear  (fault_clear),
        .top_i        (top),
        .empty_i      (empty),
        .full_i       (full),
        .push_o       (push),
        .pop_o        (pop),
        .push_data_o  (push_data),
        .stall_o      (stall_o),
        .halt_o       (halt_o),
        .nmi_o        (nmi_o),
        .ovf_o        (ovf_o),
        .fault_kind_o (fault_kind_o),
        .fault_pc_o   (fault_pc_o),
        .fault_exp_o  (fault_exp_o)
    );
endmodule

// File: rtl/ret_guard_chk.sv
module ret_guard_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rt_valid,
    input logic              rt_is_call,
    input logic              rt_is_ret,
    input logic              fault_clear,
    input logic              stall_o,
    input logic              halt_o,
    input logic              nmi_o,
    input logic              ovf_o,
    input logic [1:0]        fault_kind_o,
    input logic [ADDR_W-1:0] fault_pc_o
);
    assert_nmi_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);

    assert_nmi_with_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> halt_o);

    assert_proto_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_is_call && rt_is_ret && !halt_o && !fault_clear)
        |=> (halt_o && fault_kind_o == 2'd3));

    assert_fault_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> $stable(fault_pc_o));

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !fault_clear) |=> halt_o);

    assert_clear_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clear |=> (!halt_o && fault_kind_o == 2'd0 && !ovf_o));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !fault_clear) |=> ovf_o);

    assert_stall_only_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (rt_valid && rt_is_ret && !halt_o));

    assert_invalid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_valid && !halt_o) |=> !halt_o);
endmodule

bind ret_guard ret_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rt_valid     (rt_valid),
    .rt_is_call   (rt_is_call),
    .rt_is_ret    (rt_is_ret),
    .fault_clear  (fault_clear),
    .stall_o      (stall_o),
    .halt_o       (halt_o),
    .nmi_o        (nmi_o),
    .ovf_o        (ovf_o),
    .fault_kind_o (fault_kind_o),
    .fault_pc_o   (fault_pc_o)
);

// File: tb/ret_guard_bench.sv
`timescale 1ns/1ps
module ret_guard_bench;
    localparam int AW    = 32;
    localparam int SW    = 3;
    localparam int DEPTH = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rt_valid, rt_is_call, rt_is_ret, fault_clear;
    logic [AW-1:0] rt_pc, rt_next_pc;
    logic [SW-1:0] rt_size;
    logic          stall_o, halt_o, nmi_o, ovf_o;
    logic [1:0]    fault_kind_o;
    logic [AW-1:0] fault_pc_o, fault_exp_o;

    always #4 clk = ~clk;

    ret_guard #(.ADDR_W(AW), .SIZE_W(SW), .DEPTH(DEPTH)) u_ret_guard (
        .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_pc(rt_pc),
        .rt_size(rt_size), .rt_is_call(rt_is_call), .rt_is_ret(rt_is_ret),
        .rt_next_pc(rt_next_pc), .fault_clear(fault_clear),
        .stall_o(stall_o), .halt_o(halt_o), .nmi_o(nmi_o), .ovf_o(ovf_o),
        .fault_kind_o(fault_kind_o), .fault_pc_o(fault_pc_o),
        .fault_exp_o(fault_exp_o)
    );

    typedef struct {
        logic          halt;
        logic          nmi;
        logic          ovf;
        logic [1:0]    kind;
        logic [AW-1:0] fpc;
        logic [AW-1:0] fexp;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [AW-1:0] m_stk[$];
    logic          m_halt = 1'b0, m_ovf = 1'b0;
    logic [1:0]    m_kind = 2'd0;
    logic [AW-1:0] m_fpc = '0, m_fexp = '0;
    int            checks = 0;
    int            errors = 0;

    task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [AW-1:0] pc, logic [SW-1:0] sz, bit c,
                        bit r, logic [AW-1:0] nx, bit clr, string tag);
        exp_t          e;
        bit            flt;
        logic [1:0]    k;
        logic [AW-1:0] fx;
        @(negedge clk);
        rt_valid = v; rt_pc = pc; rt_size = sz; rt_is_call = c;
        rt_is_ret = r; rt_next_pc = nx; fault_clear = clr;
        #1;
        chk({"R9 stall ", tag}, AW'(stall_o), AW'(v && r && !m_halt));
        flt = 1'b0; k = 2'd0; fx = '0;
        if (clr) begin
            m_halt = 1'b0; m_kind = 2'd0; m_ovf = 1'b0;
        end else if (!m_halt && v) begin
            if (c && r) begin
                flt = 1'b1; k = 2'd3;
            end else if (c) begin
                if (m_stk.size() == DEPTH) m_ovf = 1'b1;
                else m_stk.push_back(pc + AW'(sz));
            end else if (r) begin
                if (m_stk.size() == 0) begin
                    flt = 1'b1; k = 2'd2;
                end else begin
                    fx = m_stk.pop_back();
                    if (fx != nx) begin flt = 1'b1; k = 2'd1; end
                    else fx = '0;
                end
            end
        end
        if (flt) begin
            m_halt = 1'b1; m_kind = k; m_fpc = pc; m_fexp = fx;
        end
        e = '{halt: m_halt, nmi: flt, ovf: m_ovf, kind: m_kind,
              fpc: m_fpc, fexp: m_fexp, tag: tag};
        @(posedge clk);
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " halt"},  AW'(halt_o),       AW'(e.halt));
            chk({e.tag, " nmi"},   AW'(nmi_o),        AW'(e.nmi));
            chk({e.tag, " ovf"},   AW'(ovf_o),        AW'(e.ovf));
            chk({e.tag, " kind"},  AW'(fault_kind_o), AW'(e.kind));
            chk({e.tag, " fpc"},   fault_pc_o,        e.fpc);
            chk({e.tag, " fexp"},  fault_exp_o,       e.fexp);
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rt_valid = 0; rt_pc = '0; rt_size = '0; rt_is_call = 0;
        rt_is_ret = 0; rt_next_pc = '0; fault_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 halt", AW'(halt_o), '0);
        chk("R10 nmi",  AW'(nmi_o), '0);
        chk("R10 ovf",  AW'(ovf_o), '0);
        chk("R10 kind", AW'(fault_kind_o), '0);
        chk("R10 fpc",  fault_pc_o, '0);
        chk("R10 fexp", fault_exp_o, '0);
        chk("R10 stall", AW'(stall_o), '0);

        // R1 matched call and return
        step(1, 32'h1000, 4, 1, 0, 32'h2000, 0, "R1 call");
        step(1, 32'h2000, 4, 0, 0, 32'h2004, 0, "R1 plain");
        step(0, 32'h0, 0, 0, 0, 32'h0, 0, "R1 idle");
        step(1, 32'h2004, 2, 0, 1, 32'h1004, 0, "R1 ret");

        // R3 nested order
        step(1, 32'h0100, 4, 1, 0, 0, 0, "R3 call a");
        step(1, 32'h0200, 2, 1, 0, 0, 0, "R3 call b");
        step(1, 32'h0300, 4, 1, 0, 0, 0, "R3 call c");
        step(1, 32'h0350, 2, 0, 1, 32'h0304, 0, "R3 ret c");
        step(1, 32'h0250, 2, 0, 1, 32'h0202, 0, "R3 ret b");
        step(1, 32'h0150, 2, 0, 1, 32'h0104, 0, "R3 ret a");

        // R11 invalid retire with flags
        step(0, 32'h0700, 4, 0, 1, 32'h1234, 0, "R11 ret flag");
        step(0, 32'h0700, 4, 1, 1, 32'h1234, 0, "R11 both flags");

        // R2 mismatch, R7 capture and ignore while halted
        step(1, 32'h0400, 4, 1, 0, 0, 0, "R2 call");
        step(1, 32'h0500, 4, 0, 1, 32'h0408, 0, "R2 bad ret");
        step(1, 32'h0600, 4, 1, 0, 0, 0, "R7 call halted");
        step(1, 32'h0610, 4, 0, 1, 32'h0000, 0, "R7 ret halted");
        step(1, 32'h0620, 4, 1, 1, 32'h0000, 0, "R7 both halted");
        step(0, 0, 0, 0, 0, 0, 0, "R8 hold");
        step(1, 32'h0630, 2, 0, 1, 32'h0000, 1, "R8 clear with ret");

        // R4 empty stack return
        step(1, 32'h0a00, 2, 0, 1, 32'h0b00, 0, "R4 empty ret");
        step(0, 0, 0, 0, 0, 0, 1, "R8 clear");

        // R6 protocol error
        step(1, 32'h0c00, 4, 1, 1, 32'h0c04, 0, "R6 both");
        step(0, 0, 0, 0, 0, 0, 1, "R8 clear proto");
        step(1, 32'h0d00, 2, 0, 1, 32'h0d04, 0, "R6 stack untouched");
        step(0, 0, 0, 0, 0, 0, 1, "R8 clear empty");

        // R5 overflow keeps stored entries
        for (int i = 0; i < DEPTH + 1; i++)
            step(1, 32'h8000 + 32'(16 * i), 4, 1, 0, 0, 0, "R5 fill");
        for (int i = DEPTH - 1; i >= 0; i--)
            step(1, 32'h9000, 2, 0, 1, 32'h8000 + 32'(16 * i) + 32'h4, 0, "R5 drain");
        step(1, 32'h9100, 2, 0, 1, 32'h8204, 0, "R5 dropped entry absent");
        step(0, 0, 0, 0, 0, 0, 1, "R5 clear ovf");
        step(0, 0, 0, 0, 0, 0, 0, "R5 after clear");

        @(negedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule